// File: doc/BRIEF.md
# AC-Link Codec Command Controller

This block is the register-level core of an AC-link audio codec controller. A CPU reaches it through a small word-addressed register window. Through that window it sets which link slots are live, drives the codec reset and sync lines directly, brings the controller clock up or down, and runs codec register reads and writes. A codec access goes through one command/response register. Writing that register raises a pending flag. The command is carried out over two link frames: it goes out on the next frame strobe, and the response is taken on the strobe after. The pending flag then drops, and for a read the returned 16-bit value can be read back for a short window of frames.

On the link side, the bit-level frame is already split into slot-wide fields. There is one transfer per frame strobe: an outgoing command slot with address and data, an incoming status slot with address and data, the incoming tag ready bit, and one outgoing and one incoming PCM sample. Two small sample FIFOs sit between the data register and the PCM slots. The status register reports empty and full for each FIFO, along with sticky underflow and overflow flags. The whole block is held cleared unless the enable register shows clock-on and not-disabled.

Top module: `aclink_cmd_ctrl`

## Requirements
- R1: After reset, and at any time the enable register does not read exactly 0x1 (bit 0 clock on, bit 1 disable off), the block is inactive. In that state the status word (0x04) reads 0x12 (both FIFOs empty), configuration reads 0, and writes to configuration, data and command are ignored.
- R2: The enable register (0x10) accepts writes at all times and reads back bits 1:0, with a reset value of 0x2. The configuration register (0x00) reads back bits 22:0 as written while the block is active.
- R3: An accepted command write to 0x0C raises pending (status bit 6) on the next cycle. At the first frame strobe after that, out_cmd_valid goes high with out_cmd_idx = word bits 6:0, out_cmd_rd = bit 7 (1 = read) and out_cmd_data = bits 31:16. At the second frame strobe, pending and out_cmd_valid clear.
- R4: When a read command completes, the command register bits 15:0 show one of two values. If in_stat_valid was high and in_stat_idx equalled the command index at the completing strobe, they show in_stat_data; otherwise they show 0xFFFF. The value stays visible for RESP_FRAMES further frame strobes, and after that the register reads 0. Bits 31:16 always read 0.
- R5: A command write that arrives while pending is set is dropped. The outstanding command's slot fields and timing are unchanged.
- R6: link_rst_n is the inverse of configuration bit 0. When configuration bit 2 (sync gate) is set, link_sync equals configuration bit 1; otherwise it follows frame_stb.
- R7: Status bit 7 (codec ready) holds the value of in_tag_ready at the most recent frame strobe, and is 0 before the first strobe.
- R8: A write to the data register (0x08) pushes bits 15:0 into the transmit FIFO. At each frame strobe where the transmit slot mask (configuration bits 12:3) is non-zero, the oldest sample is presented on out_pcm_data with out_pcm_valid until the next strobe. If the FIFO is empty at such a strobe, out_pcm_valid drops and bit 11 is set. A write to a full FIFO is dropped and sets bit 10. Status bit 4 shows transmit empty and bit 3 shows transmit full.
- R9: At each frame strobe where the receive slot mask (configuration bits 22:13) is non-zero and in_pcm_valid is high, in_pcm_data is pushed into the receive FIFO; a push into a full FIFO is dropped and sets bit 8. A read of 0x08 returns and removes the oldest sample. A read of an empty FIFO returns 0 and sets bit 9. Status bit 1 shows receive empty and bit 0 shows receive full.
- R10: Status bits 11 to 8 are sticky. Only making the block inactive clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive FIFO on 0x08) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| frame_stb | input | 1 | One-cycle pulse per link frame |
| in_tag_ready | input | 1 | Codec ready bit from the received tag slot |
| in_stat_valid | input | 1 | Received status slots carry a response |
| in_stat_idx | input | 7 | Register index in the received status address slot |
| in_stat_data | input | 16 | Received status data slot |
| in_pcm_valid | input | 1 | Received PCM slot holds a sample |
| in_pcm_data | input | 16 | Received PCM sample |
| out_cmd_valid | output | 1 | Command slots carry a command this frame |
| out_cmd_rd | output | 1 | Command is a read |
| out_cmd_idx | output | 7 | Codec register index for the command address slot |
| out_cmd_data | output | 16 | Command data slot |
| out_pcm_valid | output | 1 | Transmit PCM slot holds a sample |
| out_pcm_data | output | 16 | Transmit PCM sample |
| link_rst_n | output | 1 | Active-low codec reset line |
| link_sync | output | 1 | Link sync line |

## Verification
The hardest states to reach from the ports are a second command arriving in the gap between acceptance and the sending strobe, and a response that is present but addressed to the wrong register. The stimulus issues every random command twice in a row, the second with a different index. At the completing strobe it randomly picks one of three cases: a matching response, a mismatched index, or no valid response. The sticky FIFO flags are reached by deliberately overfilling and overdraining each FIFO by one, and a disable/enable cycle then shows that they clear.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

  localparam logic [2:0] SEL_CFG  = 3'd0;
  localparam logic [2:0] SEL_STAT = 3'd1;
  localparam logic [2:0] SEL_DATA = 3'd2;
  localparam logic [2:0] SEL_CMD  = 3'd3;
  localparam logic [2:0] SEL_EN   = 3'd4;

  localparam int CFG_W     = 23;
  localparam int CFG_RST   = 0;
  localparam int CFG_SYNC  = 1;
  localparam int CFG_GATE  = 2;

  localparam int ST_RXF = 0;
  localparam int ST_RXE = 1;
  localparam int ST_TXF = 3;
  localparam int ST_TXE = 4;
  localparam int ST_PND = 6;
  localparam int ST_RDY = 7;
  localparam int ST_RXO = 8;
  localparam int ST_RXU = 9;
  localparam int ST_TXO = 10;
  localparam int ST_TXU = 11;

  typedef enum logic [1:0] {
    CE_IDLE = 2'd0,
    CE_SEND = 2'd1,
    CE_RESP = 2'd2
  } ce_state_e;

  typedef struct packed {
    logic [15:0] wdata;
    logic        rd;
    logic [6:0]  idx;
  } codec_cmd_t;

endpackage

// File: rtl/aclink_fifo.sv
module aclink_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_d = wr_q + {{AW{1'b0}}, push};
    rd_d = rd_q + {{AW{1'b0}}, pop};
    if (clr) begin
      wr_d = '0;
      rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= din;
  end

  assign head  = mem[rd_q[AW-1:0]];
  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);

  // R8: the surrounding logic never pushes into a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: the surrounding logic never pops an empty buffer
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/aclink_cmd_engine.sv
module aclink_cmd_engine
  import aclink_pkg::*;
#(
  parameter int RESP_FRAMES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cmd_we,
  input  codec_cmd_t  cmd_in,
  input  logic        frame_stb,
  input  logic        stat_valid,
  input  logic [6:0]  stat_idx,
  input  logic [15:0] stat_data,
  output logic        out_cmd_valid,
  output logic        out_cmd_rd,
  output logic [6:0]  out_cmd_idx,
  output logic [15:0] out_cmd_data,
  output logic        pending,
  output logic [15:0] resp_data
);
  localparam int WIN_W = $clog2(RESP_FRAMES + 1);

  ce_state_e        state_q, state_d;
  codec_cmd_t       cmd_q;
  logic             cmd_load;
  logic             ovalid_q, ovalid_d;
  logic [15:0]      resp_q, resp_d;
  logic             resp_load;
  logic [WIN_W-1:0] win_q, win_d;

  always_comb begin
    state_d   = state_q;
    cmd_load  = 1'b0;
    ovalid_d  = ovalid_q;
    resp_load = 1'b0;
    resp_d    = resp_q;
    win_d     = win_q;
    if (frame_stb && (win_q != '0)) win_d = win_q - 1'b1;
    unique case (state_q)
      CE_IDLE: begin
        if (cmd_we) begin
          state_d  = CE_SEND;
          cmd_load = 1'b1;
        end
      end
      CE_SEND: begin
        if (frame_stb) begin
          state_d  = CE_RESP;
          ovalid_d = 1'b1;
        end
      end
      CE_RESP: begin
        if (frame_stb) begin
          state_d  = CE_IDLE;
          ovalid_d = 1'b0;
          if (cmd_q.rd) begin
            resp_load = 1'b1;
            resp_d    = (stat_valid && (stat_idx == cmd_q.idx)) ? stat_data : 16'hFFFF;
            win_d     = WIN_W'(RESP_FRAMES);
          end
        end
      end
      default: state_d = CE_IDLE;
    endcase
    if (clr) begin
      state_d  = CE_IDLE;
      ovalid_d = 1'b0;
      win_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CE_IDLE;
      ovalid_q <= 1'b0;
      win_q    <= '0;
    end else begin
      state_q  <= state_d;
      ovalid_q <= ovalid_d;
      win_q    <= win_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      resp_q <= '0;
    end else begin
      if (cmd_load)  cmd_q  <= cmd_in;
      if (resp_load) resp_q <= resp_d;
    end
  end

  assign pending       = (state_q != CE_IDLE);
  assign out_cmd_valid = ovalid_q;
  assign out_cmd_rd    = cmd_q.rd;
  assign out_cmd_idx   = cmd_q.idx;
  assign out_cmd_data  = cmd_q.wdata;
  assign resp_data     = (win_q != '0) ? resp_q : 16'h0000;

  // R3: an accepted command raises pending on the next cycle
  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (cmd_we && !pending) |=> pending);
  // R3: command slots open only on a frame strobe while a command waits
  p_send_on_stb_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(out_cmd_valid) |-> ($past(frame_stb) && $past(pending)));
  // R3: completion happens on a strobe after the command was on the link
  p_done_on_stb_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $fell(pending) |-> ($past(frame_stb) && $past(out_cmd_valid)));
  // R5: a write while pending leaves the outstanding command untouched
  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (cmd_we && pending) |=> ($stable(out_cmd_idx) && $stable(out_cmd_rd) && $stable(out_cmd_data)));
  // R4: a response only shows up right after a completing strobe or while the window lasts
  p_resp_window_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($past(resp_data) == 16'h0 && resp_data != 16'h0) |-> ($past(frame_stb) && $past(pending)));
endmodule

// File: rtl/aclink_pcm_path.sv
module aclink_pcm_path #(
  parameter int PCM_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             frame_stb,
  input  logic             tx_slot_en,
  input  logic             rx_slot_en,
  input  logic             data_we,
  input  logic [PCM_W-1:0] data_wdata,
  input  logic             data_re,
  input  logic             in_pcm_valid,
  input  logic [PCM_W-1:0] in_pcm_data,
  output logic             out_pcm_valid,
  output logic [PCM_W-1:0] out_pcm_data,
  output logic [PCM_W-1:0] rd_data,
  output logic             tx_unf,
  output logic             tx_ovf,
  output logic             rx_unf,
  output logic             rx_ovf,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_empty,
  output logic             rx_full
);
  logic             tx_push, tx_pop, rx_push, rx_pop;
  logic [PCM_W-1:0] tx_head, rx_head;
  logic             tx_slot, rx_slot;
  logic             txu_q, txu_d, txo_q, txo_d, rxu_q, rxu_d, rxo_q, rxo_d;
  logic             pv_q, pv_d;
  logic [PCM_W-1:0] pd_q;

  assign tx_slot = frame_stb && tx_slot_en;
  assign rx_slot = frame_stb && rx_slot_en && in_pcm_valid;
  assign tx_push = data_we && !tx_full && !clr;
  assign tx_pop  = tx_slot && !tx_empty && !clr;
  assign rx_push = rx_slot && !rx_full && !clr;
  assign rx_pop  = data_re && !rx_empty && !clr;

  aclink_fifo #(.W(PCM_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(tx_push), .din(data_wdata), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  aclink_fifo #(.W(PCM_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(rx_push), .din(in_pcm_data), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  always_comb begin
    txu_d = txu_q | (tx_slot && tx_empty);
    txo_d = txo_q | (data_we && tx_full);
    rxu_d = rxu_q | (data_re && rx_empty);
    rxo_d = rxo_q | (rx_slot && rx_full);
    pv_d  = pv_q;
    if (frame_stb) pv_d = tx_pop;
    if (clr) begin
      txu_d = 1'b0;
      txo_d = 1'b0;
      rxu_d = 1'b0;
      rxo_d = 1'b0;
      pv_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txu_q <= 1'b0;
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
      rxo_q <= 1'b0;
      pv_q  <= 1'b0;
    end else begin
      txu_q <= txu_d;
      txo_q <= txo_d;
      rxu_q <= rxu_d;
      rxo_q <= rxo_d;
      pv_q  <= pv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pd_q <= '0;
    else if (tx_pop) pd_q <= tx_head;
  end

  assign out_pcm_valid = pv_q;
  assign out_pcm_data  = pd_q;
  assign rd_data       = rx_empty ? '0 : rx_head;
  assign tx_unf        = txu_q;
  assign tx_ovf        = txo_q;
  assign rx_unf        = rxu_q;
  assign rx_ovf        = rxo_q;

  // R8: a data write into a full transmit buffer flags overflow
  p_tx_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (data_we && tx_full) |=> tx_ovf);
  // R8: a transmit sample only appears after a frame strobe
  p_pcm_on_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_pcm_valid) |-> $past(frame_stb));
  // R9: reading an empty receive buffer flags underflow
  p_rx_unf_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (data_re && rx_empty) |=> rx_unf);
  // R10: error flags hold while the block stays active
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_unf && !clr) |=> tx_unf);
endmodule

// File: rtl/aclink_cmd_ctrl.sv
module aclink_cmd_ctrl
  import aclink_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int RESP_FRAMES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        frame_stb,
  input  logic        in_tag_ready,
  input  logic        in_stat_valid,
  input  logic [6:0]  in_stat_idx,
  input  logic [15:0] in_stat_data,
  input  logic        in_pcm_valid,
  input  logic [15:0] in_pcm_data,
  output logic        out_cmd_valid,
  output logic        out_cmd_rd,
  output logic [6:0]  out_cmd_idx,
  output logic [15:0] out_cmd_data,
  output logic        out_pcm_valid,
  output logic [15:0] out_pcm_data,
  output logic        link_rst_n,
  output logic        link_sync
);
  localparam int PCM_W = 16;

  logic             rst_meta_q, rst_sync_q, rst_ni;
  logic [2:0]       sel;
  logic             active, clr;
  logic             cfg_we, en_we, cmd_we, data_we, data_re;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [1:0]       en_q, en_d;
  logic             rdy_q, rdy_d;
  codec_cmd_t       cmd_word;
  logic             pending;
  logic [15:0]      resp_data;
  logic [PCM_W-1:0] rd_data;
  logic             tx_unf, tx_ovf, rx_unf, rx_ovf;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [31:0]      stat_w;
  logic             unused_bits;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ni = rst_sync_q;

  assign sel     = bus_addr[4:2];
  assign active  = en_q[0] && !en_q[1];
  assign clr     = !active;
  assign cfg_we  = bus_we && (sel == SEL_CFG)  && active;
  assign en_we   = bus_we && (sel == SEL_EN);
  assign cmd_we  = bus_we && (sel == SEL_CMD)  && active;
  assign data_we = bus_we && (sel == SEL_DATA) && active;
  assign data_re = bus_re && (sel == SEL_DATA) && active;

  assign cmd_word.wdata = bus_wdata[31:16];
  assign cmd_word.rd    = bus_wdata[7];
  assign cmd_word.idx   = bus_wdata[6:0];
  assign unused_bits    = ^{bus_addr[1:0], bus_wdata[15:8]};

  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    rdy_d = rdy_q;
    if (cfg_we)    cfg_d = bus_wdata[CFG_W-1:0];
    if (en_we)     en_d  = bus_wdata[1:0];
    if (frame_stb) rdy_d = in_tag_ready;
    if (clr) begin
      cfg_d = '0;
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= 2'b10;
      rdy_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
      rdy_q <= rdy_d;
    end
  end

  aclink_cmd_engine #(.RESP_FRAMES(RESP_FRAMES)) u_cmd (
    .clk(clk), .rst_n(rst_ni), .clr(clr),
    .cmd_we(cmd_we), .cmd_in(cmd_word), .frame_stb(frame_stb),
    .stat_valid(in_stat_valid), .stat_idx(in_stat_idx), .stat_data(in_stat_data),
    .out_cmd_valid(out_cmd_valid), .out_cmd_rd(out_cmd_rd),
    .out_cmd_idx(out_cmd_idx), .out_cmd_data(out_cmd_data),
    .pending(pending), .resp_data(resp_data)
  );

  aclink_pcm_path #(.PCM_W(PCM_W), .DEPTH(FIFO_DEPTH)) u_pcm (
    .clk(clk), .rst_n(rst_ni), .clr(clr), .frame_stb(frame_stb),
    .tx_slot_en(|cfg_q[12:3]), .rx_slot_en(|cfg_q[22:13]),
    .data_we(data_we), .data_wdata(bus_wdata[PCM_W-1:0]), .data_re(data_re),
    .in_pcm_valid(in_pcm_valid), .in_pcm_data(in_pcm_data),
    .out_pcm_valid(out_pcm_valid), .out_pcm_data(out_pcm_data), .rd_data(rd_data),
    .tx_unf(tx_unf), .tx_ovf(tx_ovf), .rx_unf(rx_unf), .rx_ovf(rx_ovf),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[ST_TXU] = tx_unf;
    stat_w[ST_TXO] = tx_ovf;
    stat_w[ST_RXU] = rx_unf;
    stat_w[ST_RXO] = rx_ovf;
    stat_w[ST_RDY] = rdy_q;
    stat_w[ST_PND] = pending;
    stat_w[ST_TXE] = tx_empty;
    stat_w[ST_TXF] = tx_full;
    stat_w[ST_RXE] = rx_empty;
    stat_w[ST_RXF] = rx_full;
  end

  always_comb begin
    unique case (sel)
      SEL_CFG:  bus_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
      SEL_STAT: bus_rdata = stat_w;
      SEL_DATA: bus_rdata = {{(32-PCM_W){1'b0}}, rd_data};
      SEL_CMD:  bus_rdata = {16'h0000, resp_data};
      SEL_EN:   bus_rdata = {30'd0, en_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign link_rst_n = !cfg_q[CFG_RST];
  assign link_sync  = cfg_q[CFG_GATE] ? cfg_q[CFG_SYNC] : frame_stb;

  // R6: writing the reset-control bit pulls the codec reset line low
  p_rst_line_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_we && bus_wdata[CFG_RST]) |=> !link_rst_n);
  // R7: ready follows the tag bit seen at the last strobe
  p_ready_track_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_stb && active) |=> (!active || (stat_w[ST_RDY] == $past(in_tag_ready))));
  // R1: while inactive the status word shows only the two empty flags
  p_idle_status_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && $past(clr)) |-> (stat_w == 32'h12));
endmodule

// File: tb/aclink_cmd_ctrl_tb.sv
module aclink_cmd_ctrl_tb_top;
  localparam int DEPTH = 8;
  localparam logic [4:0] A_CFG = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                         A_CMD = 5'h0C, A_EN = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_stb = 1'b0, in_tag_ready = 1'b0, in_stat_valid = 1'b0;
  logic [6:0]  in_stat_idx = '0;
  logic [15:0] in_stat_data = '0;
  logic        in_pcm_valid = 1'b0;
  logic [15:0] in_pcm_data = '0;
  logic        out_cmd_valid, out_cmd_rd, out_pcm_valid, link_rst_n, link_sync;
  logic [6:0]  out_cmd_idx;
  logic [15:0] out_cmd_data, out_pcm_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  aclink_cmd_ctrl #(.FIFO_DEPTH(DEPTH), .RESP_FRAMES(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_stb(frame_stb), .in_tag_ready(in_tag_ready),
    .in_stat_valid(in_stat_valid), .in_stat_idx(in_stat_idx), .in_stat_data(in_stat_data),
    .in_pcm_valid(in_pcm_valid), .in_pcm_data(in_pcm_data),
    .out_cmd_valid(out_cmd_valid), .out_cmd_rd(out_cmd_rd),
    .out_cmd_idx(out_cmd_idx), .out_cmd_data(out_cmd_data),
    .out_pcm_valid(out_pcm_valid), .out_pcm_data(out_pcm_data),
    .link_rst_n(link_rst_n), .link_sync(link_sync)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  // expected read response per R4
  function automatic logic [15:0] exp_resp(input bit is_rd, input int mode, input logic [15:0] d);
    if (!is_rd) return 16'h0000;
    if (mode == 0) return d;
    return 16'hFFFF;
  endfunction

  function automatic logic [31:0] cmd_word(input logic [15:0] wd, input bit rd, input logic [6:0] idx);
    return {wd, 8'h00, rd, idx};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] txq [DEPTH+1];
    logic [15:0] rxq [DEPTH+1];
    rd = $urandom(32'h5EED_0A11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset state
    bus_rd(A_STAT, rd); check("R1 status after reset", rd, 32'h12);
    bus_rd(A_CFG, rd);  check("R1 cfg after reset", rd, 32'h0);
    bus_rd(A_EN, rd);   check("R2 enable reset value", rd, 32'h2);
    check("R6 reset line idle", {31'd0, link_rst_n}, 32'h1);

    // R1: writes ignored while inactive
    bus_wr(A_CFG, 32'h7);
    bus_rd(A_CFG, rd);  check("R1 cfg write ignored", rd, 32'h0);
    bus_wr(A_CMD, cmd_word(16'h1234, 1'b0, 7'h02));
    bus_rd(A_STAT, rd); check("R1 cmd write ignored", rd, 32'h12);
    bus_wr(A_EN, 32'h3);
    bus_rd(A_CFG, rd);  check("R1 both enable bits keep block idle", rd, 32'h0);

    // bring-up
    bus_wr(A_EN, 32'h1);
    bus_rd(A_EN, rd);   check("R2 enable readback", rd, 32'h1);

    // R2: configuration readback, random
    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = $urandom & 32'h007F_FFF8;
      bus_wr(A_CFG, v);
      bus_rd(A_CFG, rd); check("R2 cfg readback", rd, v);
    end

    // R6: reset and sync lines
    bus_wr(A_CFG, 32'h1);
    check("R6 reset line asserted", {31'd0, link_rst_n}, 32'h0);
    bus_wr(A_CFG, 32'h0);
    check("R6 reset line released", {31'd0, link_rst_n}, 32'h1);
    @(negedge clk); frame_stb = 1'b1; #1;
    check("R6 sync follows strobe when ungated", {31'd0, link_sync}, 32'h1);
    @(negedge clk); frame_stb = 1'b0; #1;
    check("R6 sync low between strobes", {31'd0, link_sync}, 32'h0);
    bus_wr(A_CFG, 32'h6);
    check("R6 gated sync high", {31'd0, link_sync}, 32'h1);
    bus_wr(A_CFG, 32'h4);
    @(negedge clk); frame_stb = 1'b1; #1;
    check("R6 gated sync ignores strobe", {31'd0, link_sync}, 32'h0);
    @(negedge clk); frame_stb = 1'b0;
    bus_wr(A_CFG, (32'd3 << 13) | (32'd3 << 3));

    // R7: codec ready
    bus_rd(A_STAT, rd); check("R7 ready low before strobe", {31'd0, rd[7]}, 32'h0);
    in_tag_ready = 1'b1; strobe(); in_tag_ready = 1'b0;
    bus_rd(A_STAT, rd); check("R7 ready follows tag", {31'd0, rd[7]}, 32'h1);
    strobe();
    bus_rd(A_STAT, rd); check("R7 ready drops with tag", {31'd0, rd[7]}, 32'h0);

    // R3 / R4 / R5: random codec transactions
    for (int i = 0; i < 16; i++) begin
      logic [6:0]  idx;
      logic [15:0] wd, rsp;
      bit          isrd;
      int          mode;
      idx  = 7'($urandom);
      wd   = 16'($urandom);
      isrd = bit'($urandom & 1);
      mode = int'($urandom % 3);
      rsp  = 16'($urandom);
      bus_wr(A_CMD, cmd_word(wd, isrd, idx));
      bus_rd(A_STAT, rd); check("R3 pending set", {31'd0, rd[6]}, 32'h1);
      check("R3 no slot before strobe", {31'd0, out_cmd_valid}, 32'h0);
      bus_wr(A_CMD, cmd_word(~wd, ~isrd, idx ^ 7'h55));
      strobe();
      check("R3 cmd slot valid", {31'd0, out_cmd_valid}, 32'h1);
      check("R5 cmd index kept", {25'd0, out_cmd_idx}, {25'd0, idx});
      check("R5 cmd rd kept", {31'd0, out_cmd_rd}, {31'd0, isrd});
      check("R5 cmd data kept", {16'd0, out_cmd_data}, {16'd0, wd});
      bus_rd(A_STAT, rd); check("R3 pending held over send", {31'd0, rd[6]}, 32'h1);
      in_stat_valid = (mode != 2);
      in_stat_idx   = (mode == 1) ? (idx ^ 7'h01) : idx;
      in_stat_data  = rsp;
      strobe();
      in_stat_valid = 1'b0;
      check("R3 cmd slot closed", {31'd0, out_cmd_valid}, 32'h0);
      bus_rd(A_STAT, rd); check("R3 pending cleared", {31'd0, rd[6]}, 32'h0);
      bus_rd(A_CMD, rd);  check("R4 response value", rd, {16'd0, exp_resp(isrd, mode, rsp)});
      strobe();
      bus_rd(A_CMD, rd);  check("R4 response window closed", rd, 32'h0);
    end

    // R10: disable clears sticky flags (transmit underflow was set by strobes above)
    bus_rd(A_STAT, rd); check("R10 underflow sticky", {31'd0, rd[11]}, 32'h1);
    bus_wr(A_EN, 32'h2);
    bus_rd(A_STAT, rd); check("R10 disable clears flags", rd, 32'h12);
    bus_wr(A_EN, 32'h1);
    bus_wr(A_CFG, (32'd1 << 13) | (32'd1 << 3));

    // R8: transmit path
    for (int i = 0; i <= DEPTH; i++) begin
      txq[i] = 16'($urandom);
      bus_wr(A_DATA, {16'hBEEF, txq[i]});
    end
    bus_rd(A_STAT, rd); check("R8 tx full and overflow", rd, 32'h40A);
    for (int i = 0; i < DEPTH; i++) begin
      strobe();
      check("R8 tx sample valid", {31'd0, out_pcm_valid}, 32'h1);
      check("R8 tx sample order", {16'd0, out_pcm_data}, {16'd0, txq[i]});
    end
    bus_rd(A_STAT, rd); check("R8 tx drained", rd, 32'h412);
    strobe();
    check("R8 tx valid drops when empty", {31'd0, out_pcm_valid}, 32'h0);
    bus_rd(A_STAT, rd); check("R8 tx underflow", rd, 32'hC12);

    // R9: receive path
    for (int i = 0; i <= DEPTH; i++) begin
      rxq[i] = 16'($urandom);
      in_pcm_valid = 1'b1; in_pcm_data = rxq[i];
      strobe();
    end
    in_pcm_valid = 1'b0;
    bus_rd(A_STAT, rd); check("R9 rx full and overflow", rd, 32'hD11);
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(A_DATA, rd); check("R9 rx sample order", rd, {16'd0, rxq[i]});
    end
    bus_rd(A_DATA, rd); check("R9 empty read returns zero", rd, 32'h0);
    bus_rd(A_STAT, rd); check("R9 rx underflow", rd, 32'hF12);

    // R9: zero receive mask blocks pushes
    bus_wr(A_CFG, 32'd1 << 3);
    in_pcm_valid = 1'b1; in_pcm_data = 16'hA5A5;
    strobe();
    in_pcm_valid = 1'b0;
    bus_rd(A_STAT, rd); check("R9 masked rx stays empty", {31'd0, rd[1]}, 32'h1);
    check("R10 flags survive cfg change", {28'd0, rd[11:8]}, 32'hF);

    bus_wr(A_EN, 32'h2);
    bus_rd(A_STAT, rd); check("R10 second disable clears", rd, 32'h12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule